// File: doc/BRIEF.md
# Key Event Holding Register with Interrupt

This block sits between a debounced key detector and a host. When the detector reports a valid press, the block stores the key code, starts counting duration ticks, and pulls an active-low interrupt line. The host reads the stored key type and duration whenever it likes. A read while the key is still down returns the running count. That read releases the interrupt but keeps the data. A read after the press has ended returns the final count, empties the register and releases the interrupt.

A press is ended by a release strobe or by a second valid press. Either one freezes the count and pulls the interrupt low again, so the host does not need to poll. The duration byte holds a saturating 7-bit tick count in bits 6 to 0 and an overflow flag in bit 7. The single-entry register is sized by parameters for the key code width and the count width.

Top module: `keyEventHold`

## Requirements
- R1: With no event stored, a `pressValid` strobe stores `pressKey` and a duration of zero. `irqN` reads 0 from the next cycle.
- R2: A `readStb` while the press is held leaves the key type and duration unchanged and sets `irqN` to 1 on the next cycle.
- R3: After a read during a held press, `irqN` stays 1 through any number of further reads, until a release or another press occurs.
- R4: While the press is held, each `tickStb` adds one to the count. A `releaseStb` freezes the count as the final duration and drives `irqN` to 0. Later ticks do not change it.
- R5: A `readStb` after the press has ended clears the key type and duration to zero and sets `irqN` to 1 on the next cycle.
- R6: A `pressValid` while a press is held ends that press. The earlier key and its frozen duration stay stored, `irqN` goes to 0, and the next read returns and clears that earlier event.
- R7: `durationOut` bit 7 is the overflow flag and bits 6 to 0 are the count. The count saturates at 127. A tick at 127 sets the flag instead of wrapping, so 128 or more ticks read 0xFF.
- R8: With no event stored, reads, ticks and releases have no effect. Both bytes read zero and `irqN` stays 1.
- R9: A `pressValid` while a finished event awaits reading is ignored. If it coincides with the read that clears that event, it is stored as a new press.
- R10: After reset, `irqN` is 1 and both output bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pressValid | input | 1 | One-cycle strobe: valid key press detected |
| pressKey | input | 8 | Key code accompanying `pressValid` |
| releaseStb | input | 1 | One-cycle strobe: key released |
| tickStb | input | 1 | One-cycle duration tick |
| readStb | input | 1 | One-cycle strobe: host reads the stored event |
| keyTypeOut | output | 8 | Stored key type (zero when empty) |
| durationOut | output | 8 | {overflow flag, 7-bit count} |
| irqN | output | 1 | Active-low interrupt |

## Verification
On every cycle, the assertions check these rules: how the interrupt responds to a first press, to a read during a hold, and to the end of a press; that an emptying read zeroes the data; that a saturated count and a set flag stay put; and that the count freezes outside a held press. Only the bench scenarios can show end-to-end behaviour. These include the final duration seen by the host for every tick count from 0 to 130, a second press ending an earlier one, a press ignored while a finished event waits, and a press that coincides with the clearing read.

// File: rtl/keyEventPkg.sv
package keyEventPkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_HELD  = 2'd1,
    ST_FINAL = 2'd2
  } holdState_t;

  typedef struct packed {
    logic loadKey;
    logic clearAll;
    logic countEn;
  } ctlStrobes_t;
endpackage

// File: rtl/keyEventCtl.sv
module keyEventCtl
  import keyEventPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pressValid,
  input  logic        releaseStb,
  input  logic        tickStb,
  input  logic        readStb,
  output ctlStrobes_t strobes,
  output logic        irqN
);
  holdState_t stateQ, stateD;
  logic irqQ, irqD;

  always_comb begin
    stateD  = stateQ;
    irqD    = irqQ;
    strobes = '0;
    unique case (stateQ)
      ST_EMPTY: begin
        if (pressValid) begin
          strobes.loadKey = 1'b1;
          stateD = ST_HELD;
          irqD   = 1'b0;
        end
      end
      ST_HELD: begin
        strobes.countEn = tickStb;
        if (pressValid || releaseStb) begin
          stateD = ST_FINAL;
          irqD   = 1'b0;
        end else if (readStb) begin
          irqD = 1'b1;
        end
      end
      ST_FINAL: begin
        if (readStb) begin
          strobes.clearAll = 1'b1;
          if (pressValid) begin
            strobes.loadKey = 1'b1;
            stateD = ST_HELD;
            irqD   = 1'b0;
          end else begin
            stateD = ST_EMPTY;
            irqD   = 1'b1;
          end
        end
      end
      default: begin
        stateD = ST_EMPTY;
        irqD   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_EMPTY;
      irqQ   <= 1'b1;
    end else begin
      stateQ <= stateD;
      irqQ   <= irqD;
    end
  end

  assign irqN = irqQ;

  // R1: first press pulls the interrupt
  a_r1_press_irq: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_EMPTY && pressValid) |=> !irqN);
  // R2, R3: a read with no end-of-press event releases the interrupt
  a_r3_read_release: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HELD && readStb && !pressValid && !releaseStb) |=> irqN);
  // R4, R6: end of press pulls the interrupt
  a_r4_end_irq: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HELD && (pressValid || releaseStb)) |=> !irqN);
  // R8: nothing stored means interrupt idle
  a_r8_empty_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_EMPTY) |-> irqN);
endmodule

// File: rtl/keyEventData.sv
module keyEventData
  import keyEventPkg::*;
#(
  parameter int KEY_W = 8,
  parameter int DUR_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [KEY_W-1:0] pressKey,
  output logic [KEY_W-1:0] keyTypeOut,
  output logic [DUR_W:0]   durationOut
);
  localparam logic [DUR_W-1:0] CNT_MAX = {DUR_W{1'b1}};

  logic [KEY_W-1:0] keyQ;
  logic [DUR_W-1:0] cntQ;
  logic             ovfQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ <= '0;
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else if (strobes.loadKey) begin
      keyQ <= pressKey;
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else if (strobes.clearAll) begin
      keyQ <= '0;
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else if (strobes.countEn) begin
      if (cntQ == CNT_MAX) ovfQ <= 1'b1;
      else                 cntQ <= cntQ + 1'b1;
    end
  end

  assign keyTypeOut  = keyQ;
  assign durationOut = {ovfQ, cntQ};

  // R7: saturated count holds
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == CNT_MAX && !strobes.loadKey && !strobes.clearAll) |=> (cntQ == CNT_MAX));
  // R7: overflow flag is sticky within an event
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !strobes.loadKey && !strobes.clearAll) |=> ovfQ);
  // R5: clearing read empties the register
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearAll && !strobes.loadKey) |=> (keyQ == '0 && cntQ == '0 && !ovfQ));
  // R4: count frozen outside a held press
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.countEn && !strobes.loadKey && !strobes.clearAll) |=> $stable(cntQ));
endmodule

// File: rtl/keyEventHold.sv
module keyEventHold
  import keyEventPkg::*;
#(
  parameter int KEY_W = 8,
  parameter int DUR_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pressValid,
  input  logic [KEY_W-1:0] pressKey,
  input  logic             releaseStb,
  input  logic             tickStb,
  input  logic             readStb,
  output logic [KEY_W-1:0] keyTypeOut,
  output logic [DUR_W:0]   durationOut,
  output logic             irqN
);
  ctlStrobes_t strobes;

  keyEventCtl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .pressValid (pressValid),
    .releaseStb (releaseStb),
    .tickStb    (tickStb),
    .readStb    (readStb),
    .strobes    (strobes),
    .irqN       (irqN)
  );

  keyEventData #(.KEY_W(KEY_W), .DUR_W(DUR_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pressKey    (pressKey),
    .keyTypeOut  (keyTypeOut),
    .durationOut (durationOut)
  );
endmodule

// File: tb/keyEventHold_tb.sv
`timescale 1ns/1ps
module keyEventHold_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pressValid = 1'b0, releaseStb = 1'b0, tickStb = 1'b0, readStb = 1'b0;
  logic [7:0] pressKey = '0;
  logic [7:0] keyTypeOut, durationOut;
  logic irqN;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  keyEventHold u_dut (
    .clk(clk), .rstN(rstN), .pressValid(pressValid), .pressKey(pressKey),
    .releaseStb(releaseStb), .tickStb(tickStb), .readStb(readStb),
    .keyTypeOut(keyTypeOut), .durationOut(durationOut), .irqN(irqN)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkAll(input string req, input logic [7:0] k, input logic [7:0] d, input logic i);
    chk({req, " key"}, keyTypeOut, k);
    chk({req, " dur"}, durationOut, d);
    chk({req, " irq"}, {7'd0, irqN}, {7'd0, i});
  endtask

  task automatic cyc(input logic p, input logic [7:0] k, input logic r, input logic t, input logic rd);
    @(negedge clk);
    pressValid = p; pressKey = k; releaseStb = r; tickStb = t; readStb = rd;
    @(negedge clk);
    pressValid = 0; releaseStb = 0; tickStb = 0; readStb = 0;
  endtask

  function automatic logic [7:0] expDur(input int n);
    return (n > 127) ? 8'hFF : n[7:0];
  endfunction

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkAll("R10 reset", 8'h00, 8'h00, 1'b1);
    rstN = 1'b1;
    // R8: empty register ignores read, tick, release
    cyc(0, 8'h00, 0, 0, 1); chkAll("R8 empty read", 8'h00, 8'h00, 1'b1);
    cyc(0, 8'h00, 1, 1, 0); chkAll("R8 empty rel/tick", 8'h00, 8'h00, 1'b1);

    // R1..R5 walk-through
    cyc(1, 8'h5A, 0, 0, 0); chkAll("R1 press", 8'h5A, 8'h00, 1'b0);
    repeat (5) cyc(0, 8'h00, 0, 1, 0);
    chkAll("R4 running", 8'h5A, 8'd5, 1'b0);
    cyc(0, 8'h00, 0, 0, 1); chkAll("R2 held read", 8'h5A, 8'd5, 1'b1);
    cyc(0, 8'h00, 0, 1, 1); chkAll("R3 reread", 8'h5A, 8'd6, 1'b1);
    cyc(0, 8'h00, 0, 0, 1); chkAll("R3 reread2", 8'h5A, 8'd6, 1'b1);
    cyc(0, 8'h00, 1, 0, 0); chkAll("R4 release", 8'h5A, 8'd6, 1'b0);
    repeat (3) cyc(0, 8'h00, 0, 1, 0);
    chkAll("R4 frozen", 8'h5A, 8'd6, 1'b0);
    cyc(0, 8'h00, 0, 0, 1); chkAll("R5 final read", 8'h00, 8'h00, 1'b1);

    // R7: sweep of press lengths
    for (int n = 0; n <= 130; n++) begin
      cyc(1, n[7:0] ^ 8'hC3, 0, 0, 0);
      for (int j = 0; j < n; j++) cyc(0, 8'h00, 0, 1, 0);
      cyc(0, 8'h00, 1, 0, 0);
      chkAll("R7 sweep", n[7:0] ^ 8'hC3, expDur(n), 1'b0);
      cyc(0, 8'h00, 0, 0, 1);
      chkAll("R5 sweep clear", 8'h00, 8'h00, 1'b1);
    end

    // R6: second press ends the first
    cyc(1, 8'h11, 0, 0, 0);
    repeat (4) cyc(0, 8'h00, 0, 1, 0);
    cyc(0, 8'h00, 0, 0, 1);
    cyc(1, 8'h22, 0, 0, 0); chkAll("R6 second press", 8'h11, 8'd4, 1'b0);
    cyc(0, 8'h00, 0, 1, 0); chkAll("R6 frozen", 8'h11, 8'd4, 1'b0);
    // R9: press ignored while a final event waits
    cyc(1, 8'h33, 0, 0, 0); chkAll("R9 ignored press", 8'h11, 8'd4, 1'b0);
    cyc(0, 8'h00, 0, 0, 1); chkAll("R6 read clears", 8'h00, 8'h00, 1'b1);
    // R9: press coincident with clearing read
    cyc(1, 8'h44, 0, 0, 0);
    cyc(0, 8'h00, 1, 0, 0);
    cyc(1, 8'h55, 0, 0, 1); chkAll("R9 read+press", 8'h55, 8'h00, 1'b0);
    cyc(0, 8'h00, 0, 1, 0); chkAll("R9 new counts", 8'h55, 8'd1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule